// File: doc/BRIEF.md
# Bus Cycle Timeout Monitor

This block guards a shared system bus against cycles that no slave ever acknowledges. When a master raises the address strobe and the monitor is enabled, it loads a down-counter with a programmable tick count and paces that counter with a fixed divide-by-16 prescaler. If neither the transfer acknowledge nor the end of the strobe arrives before the count runs out, the monitor drives a bus error. It holds that error until the master drops the strobe.

Each timeout also sets a sticky status flag. An error handler reads the flag to learn that the bus error came from the monitor and not from a slave. It clears the flag by writing a one. The timeout length is selected by a 3-bit field. It ranges in powers of two from 128 to 16384 clocks and is sampled once, at the start of each cycle.

Top module: `bus_timeout_mon`

## Requirements
- R1: After reset, `berr_o` and `tmo_flag_o` are both 0.
- R2: With `en_i`=1, the strobe held high and no acknowledge, `berr_o` becomes 1 exactly 16 × (8 << `tsel_i`) rising edges after the first edge that sees the strobe high. That first edge is counted as edge 0, which gives 128 clocks for select 0 and 16384 clocks for select 7.
- R3: An acknowledge sampled while the strobe is high and `berr_o` is 0 ends timing for that cycle. No bus error follows until the strobe has gone low and a new cycle starts.
- R4: A strobe that goes low before the timeout ends the cycle with no error. The next strobe starts a fresh full-length count.
- R5: Once asserted, `berr_o` stays high while the strobe and enable stay high. It goes low on the first edge that samples the strobe low.
- R6: `tmo_flag_o` becomes 1 on the same edge on which `berr_o` rises.
- R7: `tmo_flag_o` stays at 1 after `berr_o` falls, and through any later bus activity, until it is cleared or reset.
- R8: `clr_i`=1 sampled on an edge clears `tmo_flag_o`. If a timeout occurs on that same edge, the flag is set instead.
- R9: With `en_i`=0, `berr_o` is 0 from the next edge, counting is discarded, and no timeout occurs. If enable returns while the strobe is still high, a new full count starts from that edge.
- R10: `tsel_i` is sampled only on the edge that starts a cycle. Changing it during the cycle does not move that cycle's timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Monitor enable |
| tsel_i | input | 3 | Timeout select: 16 × (8 << tsel_i) clocks |
| as_i | input | 1 | Address strobe, high during a bus cycle |
| ack_i | input | 1 | Transfer acknowledge from the slave |
| clr_i | input | 1 | Write-one-to-clear pulse for the status flag |
| berr_o | output | 1 | Bus error, held until the strobe goes low |
| tmo_flag_o | output | 1 | Sticky timeout status flag |

## Verification
The bound checker watches the edge-to-edge rules on every cycle:
- bus error is never raised while disabled;
- bus error is held while the strobe stays high and released one edge after the strobe drops;
- the flag rises together with the error and persists without a clear;
- a clear takes effect unless a timeout lands on the same edge;
- no error follows an acknowledge within the same cycle.

The exact length of the timeout window is checked only by the bench. The bench measures it for every select value, runs strobes that end one edge before the limit, and changes the select in the middle of a cycle. A cycle-level reference model in the bench tracks elapsed count, acknowledge and flag state through random bursts mixed with enable drops and clears.

// File: rtl/bto_pkg.sv
package bto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_ACKED = 2'd2,
    ST_ERR   = 2'd3
  } bto_state_e;
endpackage

// File: rtl/bto_prescaler.sv
module bto_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == PRE_MAX);
endmodule

// File: rtl/bto_downcnt.sv
module bto_downcnt #(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dec_i,
  output logic             zero_o
);
  localparam int unsigned N_SEL = 1 << SEL_W;

  logic [CNT_W-1:0] reload [N_SEL];
  logic [CNT_W-1:0] cnt_q;

  // reload value is tick count minus one, so the top setting fits CNT_W
  for (genvar g = 0; g < N_SEL; g++) begin : g_reload
    localparam int unsigned TICKS = 1 << (BASE_LOG2 + g);
    assign reload[g] = CNT_W'(TICKS - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (load_i)          cnt_q <= reload[sel_i];
    else if (dec_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bto_status.sv
module bto_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;   // set wins over clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/bto_ctrl.sv
module bto_ctrl
  import bto_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic as_i,
  input  logic ack_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic tmo_set_o,
  output logic berr_o
);
  bto_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    tmo_set_o = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (as_i) begin
          load_o  = 1'b1;
          state_d = ack_i ? ST_ACKED : ST_COUNT;
        end
        ST_COUNT: begin
          if (!as_i)         state_d = ST_IDLE;
          else if (ack_i)    state_d = ST_ACKED;
          else if (expire_i) begin
            state_d   = ST_ERR;
            tmo_set_o = 1'b1;
          end
        end
        ST_ACKED: if (!as_i) state_d = ST_IDLE;
        ST_ERR:   if (!as_i) state_d = ST_IDLE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o  = en_i && (state_q == ST_COUNT) && as_i && !ack_i;
  assign berr_o = (state_q == ST_ERR);
endmodule

// File: rtl/bus_timeout_mon.sv
module bus_timeout_mon #(
  parameter int unsigned PRE_W     = 4,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned BASE_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] tsel_i,
  input  logic             as_i,
  input  logic             ack_i,
  input  logic             clr_i,
  output logic             berr_o,
  output logic             tmo_flag_o
);
  logic load, run, tick, zero, tmo_set;

  bto_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .as_i      (as_i),
    .ack_i     (ack_i),
    .expire_i  (tick && zero),
    .load_o    (load),
    .run_o     (run),
    .tmo_set_o (tmo_set),
    .berr_o    (berr_o)
  );

  bto_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!en_i || load),
    .run_i   (run),
    .tick_o  (tick)
  );

  bto_downcnt #(.CNT_W(CNT_W), .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (!en_i),
    .load_i  (load),
    .sel_i   (tsel_i),
    .dec_i   (tick),
    .zero_o  (zero)
  );

  bto_status u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tmo_set),
    .clr_i  (clr_i),
    .flag_o (tmo_flag_o)
  );
endmodule

// File: rtl/bto_chk.sv
module bto_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic as_i,
  input logic ack_i,
  input logic clr_i,
  input logic berr_o,
  input logic tmo_flag_o
);
  logic acked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            acked_q <= 1'b0;
    else if (!en_i || !as_i)                acked_q <= 1'b0;
    else if (ack_i && !berr_o)              acked_q <= 1'b1;
  end

  // R9
  dis_no_berr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !berr_o);
  // R5
  berr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o && as_i && en_i |=> berr_o);
  // R5
  berr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |=> !berr_o);
  // R2
  berr_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(berr_o) |-> $past(as_i) && $past(en_i));
  // R6
  flag_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(berr_o) |-> tmo_flag_o);
  // R7
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_flag_o && !clr_i |=> tmo_flag_o);
  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tmo_flag_o || $rose(berr_o));
  // R3
  no_err_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acked_q |-> !berr_o);
endmodule

bind bus_timeout_mon bto_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .as_i       (as_i),
  .ack_i      (ack_i),
  .clr_i      (clr_i),
  .berr_o     (berr_o),
  .tmo_flag_o (tmo_flag_o)
);

// File: tb/sim_bus_timeout_mon.sv
`timescale 1ns/1ps
module sim_bus_timeout_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, as_s = 1'b0, ack = 1'b0, clr = 1'b0;
  logic [2:0] tsel = '0;
  logic       berr, flag;

  int    nvec = 0, nerr = 0;
  string tag = "R1";
  bit    m_act, m_ack, m_berr, m_flag;
  int    m_el, m_lim;

  always #5 clk = ~clk;

  bus_timeout_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tsel_i(tsel),
    .as_i(as_s), .ack_i(ack), .clr_i(clr), .berr_o(berr), .tmo_flag_o(flag)
  );

  function automatic int limit_of(input logic [2:0] t);
    return 16 * (8 << t);
  endfunction

  task automatic model_edge();
    bit set = 0;
    if (!en) begin
      m_act = 0; m_berr = 0;
    end else if (!as_s) begin
      m_act = 0; m_berr = 0; m_ack = 0;
    end else if (m_berr) begin
    end else if (!m_act) begin
      m_act = 1; m_el = 0; m_lim = limit_of(tsel); m_ack = ack;
    end else if (m_ack) begin
    end else if (ack) begin
      m_ack = 1;
    end else begin
      m_el++;
      if (m_el == m_lim) begin m_berr = 1; set = 1; end
    end
    if (set) m_flag = 1;
    else if (clr) m_flag = 0;
  endtask

  task automatic check(input string t, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    nvec++;
    if (berr !== m_berr || flag !== m_flag) begin
      nerr++;
      $display("FAIL %s: actual berr=%b flag=%b expected berr=%b flag=%b",
               tag, berr, flag, m_berr, m_flag);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_clr();
    clr = 1; tick(); clr = 0;
  endtask

  // R2: measure edges from strobe start to error
  task automatic measure(input logic [2:0] t);
    int n = 0;
    tag = "R2"; tsel = t; as_s = 1;
    do begin tick(); n++; end while (!berr && n < 20000);
    check("R2", n, limit_of(t) + 1);
    tag = "R5"; ticks(3);
    check("R5", berr, 1);
    as_s = 0; tick();
    check("R5", berr, 0);
    tag = "R7"; ticks(2);
    check("R7", flag, 1);
    tag = "R8"; pulse_clr();
    check("R8", flag, 0);
  endtask

  initial begin
    #(200000 * 10);
    nerr++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_act = 0; m_ack = 0; m_berr = 0; m_flag = 0; m_el = 0; m_lim = 0;
    repeat (3) @(negedge clk);
    check("R1", berr, 0);
    check("R1", flag, 0);
    rst_n = 1;
    en = 1;
    ticks(2);

    for (int t = 0; t < 8; t++) begin
      measure(3'(t));
      ticks(2);
    end

    // R4: strobe ends one edge before the limit, then a full cycle
    tag = "R4"; tsel = 0; as_s = 1;
    ticks(limit_of(0));
    as_s = 0; tick();
    check("R4", berr, 0);
    as_s = 1; ticks(limit_of(0));
    check("R4", berr, 0);
    tick();
    check("R4", berr, 1);
    as_s = 0; tick(); pulse_clr();

    // R3: acknowledge mid cycle, strobe held well past limit
    tag = "R3"; as_s = 1; ticks(40);
    ack = 1; tick(); ack = 0;
    ticks(limit_of(0) + 50);
    check("R3", berr, 0);
    check("R3", flag, 0);
    as_s = 0; tick();

    // R8: clear on the same edge as timeout, set wins
    tag = "R8"; as_s = 1; ticks(limit_of(0));
    clr = 1; tick(); clr = 0;
    check("R8", flag, 1);
    as_s = 0; tick(); pulse_clr();

    // R9: disabled, long strobe
    tag = "R9"; en = 0; as_s = 1; ticks(limit_of(0) + 20);
    check("R9", berr, 0);
    en = 1; ticks(limit_of(0));
    check("R9", berr, 0);
    tick();
    check("R9", berr, 1);
    en = 0; tick();
    check("R9", berr, 0);
    en = 1; as_s = 0; tick(); pulse_clr();

    // R10: select change mid cycle has no effect
    tag = "R10"; tsel = 0; as_s = 1; ticks(10);
    tsel = 7; ticks(limit_of(0) - 10);
    check("R10", berr, 0);
    tick();
    check("R10", berr, 1);
    as_s = 0; tsel = 0; tick(); pulse_clr();

    // random bursts, R2..R9
    tag = "R2-random";
    for (int b = 0; b < 150; b++) begin
      int len = 1 + ($urandom % 300);
      int ack_at = ($urandom % 4 == 0) ? ($urandom % len) : -1;
      tsel = 3'($urandom % 2);
      en = ($urandom % 8) != 0;
      as_s = 1;
      for (int i = 0; i < len; i++) begin
        ack = (i == ack_at);
        clr = ($urandom % 64) == 0;
        if (($urandom % 200) == 0) en = ~en;
        tick();
      end
      ack = 0; clr = 0; as_s = 0;
      ticks(1 + $urandom % 4);
    end
    en = 1; ticks(2);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule